// File: doc/BRIEF.md
# Multi-channel PWM with shadowed duty updates

This block drives a bank of pulse-width outputs from one shared time base. A prescaler divides the APB clock into counting ticks. On each tick a period counter steps from zero up to a programmable limit and then wraps. Every channel compares that counter against its own turn-on and turn-off positions. The result is registered and then gated by an output-enable mask.

Each channel can be built with or without a second copy of its two position registers. On a channel built with that copy, a run-time mask bit picks one of two update modes. In the first, a new position is written into the copy and moves into the active register at the next period start, so no period is ever cut short. In the second, the new position takes effect at once. Channels built without the copy always update at once, and their mask bit is ignored. Changes to the period limit and to the prescaler are always held until the next period start.

Top module: `pwm_shadow_bank`

## Requirements
- R1: After reset, all outputs are 0 and the registers read: prescaler 0, period limit all ones (255 with the default 8-bit counter), enable mask 0, update mask 0, and all positions 0.
- R2: APB accesses complete in the access phase with PREADY=1 and PSLVERR=0. The map is: prescaler 0x00, period limit 0x04, enable mask 0x08, update mask 0x0C, channel c turn-on at 0x10+8c and turn-off at 0x14+8c. Values written read back unchanged.
- R3: The counter advances once every prescaler+1 clocks and wraps from the period limit to 0, so one period lasts (limit+1)·(prescaler+1) clocks.
- R4: An output rises one clock after the counter first shows the turn-on value and falls one clock after it first shows the turn-off value. For on < off, the high time is (off−on)·(prescaler+1) clocks.
- R5: For on > off, the high time per period is (limit+1−(on−off))·(prescaler+1) clocks. Equal positions keep the output low. With on = 0 and off > limit, the output stays high.
- R6: Output c is forced low while bit c of the enable mask is 0.
- R7: With its update-mask bit clear, a position written to a copy-equipped channel changes that channel's output within the current period.
- R8: With its update-mask bit set, a position written to a copy-equipped channel takes effect only from the next period start.
- R9: On channels built without the copy, the update-mask bit reads 0 and has no effect: writes always apply at once.
- R10: A new period limit or prescaler value is applied only at the wrap, so the period in progress finishes with its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock for the APB and the PWM logic |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| pwm_o | output | NCH | Gated PWM outputs |

## Verification
A register write is stored at the clock edge that ends the APB access phase. A readback is valid in that same access phase, because the read multiplexer is combinational. An output edge appears one clock after the counter shows the matching position. The period limit, the prescaler and any deferred position are applied at the wrap edge. For these reasons the bench never checks the output at a fixed cycle number. It samples on falling clock edges and measures whole high and low runs. Every write meant to land mid-period is issued just after an observed rising edge, which places it in a known range of counter values, well before both the next turn-off position and the wrap.

// File: rtl/pwmsb_pkg.sv
package pwmsb_pkg;

  // Byte offsets of the control words; channel words follow from CH_BASE.
  localparam int OFF_PRESCALE = 'h00;
  localparam int OFF_PERIOD   = 'h04;
  localparam int OFF_ENABLE   = 'h08;
  localparam int OFF_UPDMASK  = 'h0C;
  localparam int CH_BASE      = 'h10;
  localparam int CH_STRIDE    = 8;

  // Address of a channel's turn-on word (off_word selects the turn-off word).
  function automatic int chan_addr(input int ch, input bit off_word);
    return CH_BASE + CH_STRIDE * ch + (off_word ? 4 : 0);
  endfunction

  // Output level update: a turn-off hit wins over a turn-on hit.
  function automatic logic next_level(input logic cur, input logic hit_on,
                                      input logic hit_off);
    if (hit_off)     return 1'b0;
    else if (hit_on) return 1'b1;
    else             return cur;
  endfunction

endpackage

// File: rtl/pwmsb_apb_regs.sv
module pwmsb_apb_regs
  import pwmsb_pkg::*;
#(
  parameter int          NCH         = 4,
  parameter int          CW          = 8,
  parameter int          AW          = 8,
  parameter logic [NCH-1:0] SHADOW_MASK = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  input  logic [AW-1:0]           paddr,
  input  logic [31:0]             pwdata,
  input  logic [NCH-1:0][CW-1:0]  rd_on,
  input  logic [NCH-1:0][CW-1:0]  rd_off,
  output logic [31:0]             prdata,
  output logic [CW-1:0]           prescale_q,
  output logic [CW-1:0]           period_q,
  output logic [NCH-1:0]          enable_q,
  output logic [NCH-1:0]          updmask_q,
  output logic [NCH-1:0]          wr_on,
  output logic [NCH-1:0]          wr_off,
  output logic [CW-1:0]           wval
);

  logic wr_en;
  logic wr_prescale, wr_period, wr_enable, wr_updmask;
  logic unused_hi;

  assign wr_en       = psel && penable && pwrite;
  assign wval        = pwdata[CW-1:0];
  assign unused_hi   = ^pwdata[31:CW];
  assign wr_prescale = wr_en && (paddr == AW'(OFF_PRESCALE));
  assign wr_period   = wr_en && (paddr == AW'(OFF_PERIOD));
  assign wr_enable   = wr_en && (paddr == AW'(OFF_ENABLE));
  assign wr_updmask  = wr_en && (paddr == AW'(OFF_UPDMASK));

  for (genvar c = 0; c < NCH; c++) begin : g_strobe
    localparam logic [AW-1:0] ON_ADDR  = AW'(chan_addr(c, 1'b0));
    localparam logic [AW-1:0] OFF_ADDR = AW'(chan_addr(c, 1'b1));
    assign wr_on[c]  = wr_en && (paddr == ON_ADDR);
    assign wr_off[c] = wr_en && (paddr == OFF_ADDR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prescale_q <= '0;
      period_q   <= '1;
      enable_q   <= '0;
      updmask_q  <= '0;
    end else begin
      if (wr_prescale) prescale_q <= pwdata[CW-1:0];
      if (wr_period)   period_q   <= pwdata[CW-1:0];
      if (wr_enable)   enable_q   <= pwdata[NCH-1:0];
      // Mask bits exist only for channels built with a shadow copy.
      if (wr_updmask)  updmask_q  <= pwdata[NCH-1:0] & SHADOW_MASK;
    end
  end

  always_comb begin
    prdata = '0;
    if (paddr == AW'(OFF_PRESCALE)) prdata = 32'(prescale_q);
    if (paddr == AW'(OFF_PERIOD))   prdata = 32'(period_q);
    if (paddr == AW'(OFF_ENABLE))   prdata = 32'(enable_q);
    if (paddr == AW'(OFF_UPDMASK))  prdata = 32'(updmask_q);
    for (int c = 0; c < NCH; c++) begin
      if (paddr == AW'(chan_addr(c, 1'b0))) prdata = 32'(rd_on[c]);
      if (paddr == AW'(chan_addr(c, 1'b1))) prdata = 32'(rd_off[c]);
    end
  end

  // R2
  period_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_period |=> period_q == $past(pwdata[CW-1:0]));

  // R9
  updmask_shadow_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_updmask |=> (updmask_q & ~SHADOW_MASK) == '0);

endmodule

// File: rtl/pwmsb_timebase.sv
module pwmsb_timebase #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] prescale_q,
  input  logic [CW-1:0] period_q,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);

  logic [CW-1:0] pre_act, per_act, pre_cnt, cnt;
  logic          tick;

  assign tick   = (pre_cnt == pre_act);
  assign wrap_o = tick && (cnt == per_act);
  assign cnt_o  = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_act <= '0;
      per_act <= '1;
      pre_cnt <= '0;
      cnt     <= '0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) cnt <= wrap_o ? '0 : cnt + 1'b1;
      // New limits are taken only at the period boundary.
      if (wrap_o) begin
        pre_act <= prescale_q;
        per_act <= period_q;
      end
    end
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_act);

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt == '0);

  // R3
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R10
  limits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_o |=> $stable(per_act) && $stable(pre_act));

endmodule

// File: rtl/pwmsb_channel.sv
module pwmsb_channel
  import pwmsb_pkg::*;
#(
  parameter int CW       = 8,
  parameter bit SHADOWED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          wrap_i,
  input  logic          sync_i,
  input  logic          wr_on_i,
  input  logic          wr_off_i,
  input  logic [CW-1:0] wval_i,
  output logic          level_o,
  output logic [CW-1:0] rd_on_o,
  output logic [CW-1:0] rd_off_o
);

  logic [CW-1:0] act_on, act_off;
  logic          out_q;
  logic          hit_on, hit_off;

  if (SHADOWED) begin : g_shadow
    logic [CW-1:0] pend_on, pend_off;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_on  <= '0;
        pend_off <= '0;
        act_on   <= '0;
        act_off  <= '0;
      end else begin
        if (wr_on_i)  pend_on  <= wval_i;
        if (wr_off_i) pend_off <= wval_i;
        if (wr_on_i && !sync_i)  act_on <= wval_i;
        else if (wrap_i)         act_on <= pend_on;
        if (wr_off_i && !sync_i) act_off <= wval_i;
        else if (wrap_i)         act_off <= pend_off;
      end
    end

    assign rd_on_o  = pend_on;
    assign rd_off_o = pend_off;

    // R8
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wrap_i && sync_i) |=> $stable(act_on) && $stable(act_off));

  end else begin : g_direct
    logic unused_ctl;
    assign unused_ctl = sync_i ^ wrap_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_on  <= '0;
        act_off <= '0;
      end else begin
        if (wr_on_i)  act_on  <= wval_i;
        if (wr_off_i) act_off <= wval_i;
      end
    end

    assign rd_on_o  = act_on;
    assign rd_off_o = act_off;

    // R9
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_off_i |=> act_off == $past(wval_i));
  end

  assign hit_on  = (cnt_i == act_on);
  assign hit_off = (cnt_i == act_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= next_level(out_q, hit_on, hit_off);
  end

  assign level_o = out_q;

  // R4
  rise_at_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(cnt_i) == $past(act_on));

  // R4
  fall_at_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_off |=> !out_q);

endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank #(
  parameter int             NCH         = 4,
  parameter int             CW          = 8,
  parameter int             AW          = 8,
  parameter logic [NCH-1:0] SHADOW_MASK = 4'b0011
) (
  input  logic           pclk,
  input  logic           presetn,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [AW-1:0]  paddr,
  input  logic [31:0]    pwdata,
  output logic [31:0]    prdata,
  output logic           pready,
  output logic           pslverr,
  output logic [NCH-1:0] pwm_o
);

  logic [CW-1:0]           prescale_q, period_q, cnt, wval;
  logic [NCH-1:0]          enable_q, updmask_q, wr_on, wr_off, level;
  logic [NCH-1:0][CW-1:0]  rd_on, rd_off;
  logic                    wrap;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  pwmsb_apb_regs #(.NCH(NCH), .CW(CW), .AW(AW), .SHADOW_MASK(SHADOW_MASK)) regs_i (
    .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .rd_on(rd_on), .rd_off(rd_off),
    .prdata(prdata), .prescale_q(prescale_q), .period_q(period_q),
    .enable_q(enable_q), .updmask_q(updmask_q), .wr_on(wr_on), .wr_off(wr_off),
    .wval(wval)
  );

  pwmsb_timebase #(.CW(CW)) tb_i (
    .clk(pclk), .rst_n(presetn), .prescale_q(prescale_q), .period_q(period_q),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwmsb_channel #(.CW(CW), .SHADOWED(SHADOW_MASK[c])) ch_i (
      .clk(pclk), .rst_n(presetn), .cnt_i(cnt), .wrap_i(wrap),
      .sync_i(updmask_q[c]), .wr_on_i(wr_on[c]), .wr_off_i(wr_off[c]),
      .wval_i(wval), .level_o(level[c]), .rd_on_o(rd_on[c]), .rd_off_o(rd_off[c])
    );
  end

  assign pwm_o = level & enable_q;

  // R6
  gated_low_chk: assert property (@(posedge pclk) disable iff (!presetn)
    $fell(enable_q[0]) |-> !pwm_o[0]);

endmodule

// File: tb/pwm_shadow_bank_tb_top.sv
`timescale 1ns/1ps
module pwm_shadow_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [3:0]  pwm;
  int          checks = 0;
  int          fails  = 0;

  always #4 clk = ~clk;

  pwm_shadow_bank dut_i (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .pwm_o(pwm)
  );

  function automatic logic [7:0] a_on(input int ch);
    return 8'(16 + 8 * ch);
  endfunction
  function automatic logic [7:0] a_off(input int ch);
    return 8'(20 + 8 * ch);
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [7:0] a, output int d, output int hs);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d  = int'(prdata);
    hs = (pready && !pslverr) ? 1 : 0;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic skip_lvl(input int ch, input logic lvl);
    while (pwm[ch] == lvl) @(negedge clk);
  endtask

  task automatic run_len(input int ch, input logic lvl, output int n);
    n = 0;
    while (pwm[ch] == lvl) begin n++; @(negedge clk); end
  endtask

  task automatic wait_rise(input int ch);
    skip_lvl(ch, 1'b1);
    skip_lvl(ch, 1'b0);
  endtask

  task automatic const_level(input int ch, input logic lvl, input int ncyc,
                             input string req);
    int bad = 0;
    for (int i = 0; i < ncyc; i++) begin
      if (pwm[ch] != lvl) bad++;
      @(negedge clk);
    end
    check_eq(req, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int d, hs, n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_eq("R1 outputs", int'(pwm), 0);
    apb_read(8'h00, d, hs); check_eq("R1 prescale", d, 0);
    apb_read(8'h04, d, hs); check_eq("R1 period", d, 255);
    apb_read(8'h08, d, hs); check_eq("R1 enable", d, 0);
    apb_read(8'h0C, d, hs); check_eq("R1 updmask", d, 0);
    apb_read(a_off(3), d, hs); check_eq("R1 position", d, 0);
    check_eq("R2 handshake", hs, 1);

    // R2 configuration and readback
    apb_write(8'h04, 32'd15);
    apb_read(8'h04, d, hs); check_eq("R2 period readback", d, 15);
    apb_write(a_on(0), 32'd2);  apb_write(a_off(0), 32'd6);
    apb_write(a_on(1), 32'd0);  apb_write(a_off(1), 32'd20);
    apb_write(a_on(2), 32'd5);  apb_write(a_off(2), 32'd3);
    apb_write(a_on(3), 32'd7);  apb_write(a_off(3), 32'd7);
    apb_write(8'h08, 32'hF);
    apb_read(a_on(2), d, hs); check_eq("R2 on readback", d, 5);
    repeat (300) @(negedge clk);

    // R3/R4 basic duty, period 16
    wait_rise(0); run_len(0, 1'b1, n); check_eq("R4 high run", n, 4);
    run_len(0, 1'b0, n); check_eq("R3 low run", n, 12);
    // R5 corner encodings
    wait_rise(2); run_len(2, 1'b1, n); check_eq("R5 wrapped high", n, 14);
    const_level(3, 1'b0, 40, "R5 equal positions low");
    const_level(1, 1'b1, 40, "R5 always high");

    // R3/R10 prescaler 2
    apb_write(8'h00, 32'd2);
    repeat (120) @(negedge clk);
    wait_rise(0); run_len(0, 1'b1, n); check_eq("R3 prescaled high", n, 12);
    run_len(0, 1'b0, n); check_eq("R3 prescaled low", n, 36);
    apb_write(8'h00, 32'd0);
    repeat (120) @(negedge clk);

    // R6 enable mask
    apb_write(8'h08, 32'hD);
    const_level(1, 1'b0, 40, "R6 disabled low");
    apb_write(8'h08, 32'hF);
    repeat (3) @(negedge clk);
    check_eq("R6 re-enabled", int'(pwm[1]), 1);

    // R7 immediate update on shadow-capable channel
    wait_rise(0);
    fork
      apb_write(a_off(0), 32'd10);
      run_len(0, 1'b1, n);
    join
    check_eq("R7 immediate high", n, 8);

    // R8/R9 update mask
    apb_write(8'h0C, 32'hF);
    apb_read(8'h0C, d, hs); check_eq("R9 mask readback", d, 3);
    apb_write(a_off(0), 32'd6);
    apb_write(a_on(2), 32'd2);
    apb_write(a_off(2), 32'd6);
    repeat (40) @(negedge clk);
    wait_rise(0);
    fork
      apb_write(a_off(0), 32'd12);
      run_len(0, 1'b1, n);
    join
    check_eq("R8 deferred high", n, 4);
    skip_lvl(0, 1'b0);
    run_len(0, 1'b1, n); check_eq("R8 applied next period", n, 10);

    wait_rise(2);
    fork
      apb_write(a_off(2), 32'd12);
      run_len(2, 1'b1, n);
    join
    check_eq("R9 mask ignored", n, 10);

    // R10 period change deferred to the wrap
    apb_write(a_on(3), 32'd2);
    apb_write(a_off(3), 32'd4);
    repeat (40) @(negedge clk);
    wait_rise(3);
    fork
      apb_write(8'h04, 32'd7);
      begin skip_lvl(3, 1'b1); run_len(3, 1'b0, n); end
    join
    check_eq("R10 old period finishes", n, 14);
    run_len(3, 1'b1, n); check_eq("R10 high after change", n, 2);
    run_len(3, 1'b0, n); check_eq("R10 new period low", n, 6);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule